// File: doc/BRIEF.md
# Three-Level Phase-Leg Gate Sequencer

This block turns a level request for one leg of a three-level T-type inverter into gate commands for the leg's three switches. These are the switch to the positive rail, the switch to the negative rail, and the bidirectional clamp to the midpoint. At most one switch conducts at a time. Each change of requested level is separated by a blanking gap in which every gate is low. The width of the gap is set in clock cycles by a runtime input, so the DC link can never be shorted through two conducting switches.

A modulator upstream presents a 2-bit level on every cycle. The sequencer keeps the level it is currently serving (the target) and compares each new sample with it. It is built around three states:
- IDLE: held while reset is high.
- BLANK: all gates off while the gap timer runs.
- DRIVE: the target's single gate is on.

The transitions are:
- START: IDLE to BLANK, on the first clock edge without reset.
- WAIT: BLANK to BLANK, while the gap is still running.
- RESTART: BLANK to BLANK, when the request changes during a gap. The timer clears and the new value becomes the target.
- SETTLE: BLANK to DRIVE, when the gap has elapsed.
- HOLD: DRIVE to DRIVE, while the request is unchanged.
- CHANGE: DRIVE to BLANK, when the request differs from the target.

Top module: `tleg_gate_seq`

## Requirements
- R1: Once settled, request 2'b01 drives only `gate_up`, 2'b00 drives only `gate_mid` and 2'b11 drives only `gate_dn`.
- R2: Request 2'b10 is illegal. After its gap it leaves all three gates low for as long as it is held.
- R3: On the first cycle after the clock edge that samples a request different from the target, all gates are low.
- R4: After a change, all gates stay low for exactly max(`dead_cycles`,1) cycles. The new gate then rises on the next cycle.
- R5: A request change sampled while gates are blanked restarts the gap from zero. The gap ends on the newest request.
- R6: All gates are low while `rst` is high. After release, all gates stay low for max(`dead_cycles`,1) cycles, counted from the first edge with `rst` low.
- R7: On every clock edge the three gates are one-hot or all low.
- R8: While the request stays equal to the target, an asserted gate holds without glitching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_cmd | input | 2 | Requested level: 01 positive, 00 midpoint, 11 negative, 10 illegal |
| dead_cycles | input | DEAD_W | Blanking gap length in cycles; 0 behaves as 1 |
| gate_up | output | 1 | Gate of the switch to the positive rail |
| gate_mid | output | 1 | Gate of the bidirectional midpoint clamp |
| gate_dn | output | 1 | Gate of the switch to the negative rail |

## Verification
The bench sweeps every ordered pair of the four request codes over several gap lengths, including 0 and 1. An off-by-one timer would show up there as a gap one cycle short or long, and a design that skipped blanking on some pairs would show two gates changing in the same cycle. It changes the request again at every point inside a gap, including the cycle on which the gap would have ended. A design that keeps counting instead of restarting would then turn on a gate early, or the gate of a stale level. It also holds the illegal code and a long reset. A design that decoded 2'b10 to some switch, or drove a gate straight out of reset, would be caught there.

// File: rtl/tleg_pkg.sv
package tleg_pkg;

    // Requested leg level; the code values are part of the port contract
    typedef enum logic [1:0] {
        LVL_MID = 2'b00,
        LVL_POS = 2'b01,
        LVL_BAD = 2'b10,
        LVL_NEG = 2'b11
    } level_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_BLANK = 2'b01,
        ST_DRIVE = 2'b10
    } leg_state_e;

    // Gate vector bit positions {up, mid, dn}
    localparam int GATE_N  = 3;
    localparam int G_UP    = 2;
    localparam int G_MID   = 1;
    localparam int G_DN    = 0;

endpackage

// File: rtl/tleg_level_decode.sv
module tleg_level_decode
    import tleg_pkg::*;
(
    input  logic [1:0]        level,
    input  logic              enable,
    output logic [GATE_N-1:0] gates
);

    always_comb begin
        gates = '0;
        if (enable) begin
            unique case (level)
                LVL_POS: gates[G_UP]  = 1'b1;
                LVL_MID: gates[G_MID] = 1'b1;
                LVL_NEG: gates[G_DN]  = 1'b1;
                default: gates        = '0;
            endcase
        end
    end

endmodule

// File: rtl/tleg_blank_timer.sv
module tleg_blank_timer #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              run,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              expired
);

    localparam int CW = DEAD_W + 1;

    logic [DEAD_W-1:0] elapsed;
    logic [CW-1:0]     span;
    logic [CW-1:0]     next_elapsed;

    // A zero setting still yields one blank cycle
    always_comb begin
        span         = (dead_cycles == '0) ? CW'(1) : {1'b0, dead_cycles};
        next_elapsed = {1'b0, elapsed} + CW'(1);
        expired      = (next_elapsed >= span);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            elapsed <= '0;
        end else if (run && !expired) begin
            elapsed <= elapsed + 1'b1;
        end
    end

endmodule

// File: rtl/tleg_leg_fsm.sv
module tleg_leg_fsm
    import tleg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] level_cmd,
    input  logic       expired,
    output logic [1:0] target,
    output logic       drive_en,
    output logic       timer_clear,
    output logic       timer_run
);

    leg_state_e state;
    logic       differs;

    assign differs = (level_cmd != target);

    // State and target register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            target <= LVL_BAD;
        end else begin
            unique case (state)
                ST_IDLE: begin                      // START
                    state  <= ST_BLANK;
                    target <= level_cmd;
                end
                ST_BLANK: begin
                    if (differs) begin              // RESTART
                        state  <= ST_BLANK;
                        target <= level_cmd;
                    end else if (expired) begin     // SETTLE
                        state  <= ST_DRIVE;
                    end else begin                  // WAIT
                        state  <= ST_BLANK;
                    end
                end
                ST_DRIVE: begin
                    if (differs) begin              // CHANGE
                        state  <= ST_BLANK;
                        target <= level_cmd;
                    end else begin                  // HOLD
                        state  <= ST_DRIVE;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    target <= LVL_BAD;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        drive_en    = 1'b0;
        timer_clear = 1'b0;
        timer_run   = 1'b0;
        unique case (state)
            ST_IDLE:  timer_clear = 1'b1;
            ST_BLANK: begin
                timer_run   = 1'b1;
                timer_clear = differs;
            end
            ST_DRIVE: begin
                drive_en    = 1'b1;
                timer_clear = differs;
            end
            default:  timer_clear = 1'b1;
        endcase
    end

endmodule

// File: rtl/tleg_gate_seq.sv
module tleg_gate_seq
    import tleg_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        level_cmd,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              gate_up,
    output logic              gate_mid,
    output logic              gate_dn
);

    logic [1:0]        target;
    logic              drive_en;
    logic              timer_clear;
    logic              timer_run;
    logic              expired;
    logic [GATE_N-1:0] gates;

    tleg_leg_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .level_cmd   (level_cmd),
        .expired     (expired),
        .target      (target),
        .drive_en    (drive_en),
        .timer_clear (timer_clear),
        .timer_run   (timer_run)
    );

    tleg_blank_timer #(.DEAD_W(DEAD_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .clear       (timer_clear),
        .run         (timer_run),
        .dead_cycles (dead_cycles),
        .expired     (expired)
    );

    tleg_level_decode u_dec (
        .level  (target),
        .enable (drive_en),
        .gates  (gates)
    );

    assign gate_up  = gates[G_UP];
    assign gate_mid = gates[G_MID];
    assign gate_dn  = gates[G_DN];

endmodule

// File: rtl/tleg_gate_seq_chk.sv
module tleg_gate_seq_chk #(
    parameter int DEAD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        level_cmd,
    input logic [DEAD_W-1:0] dead_cycles,
    input logic              gate_up,
    input logic              gate_mid,
    input logic              gate_dn
);

    localparam int RW = DEAD_W + 1;

    logic [2:0]    g;
    logic [RW-1:0] off_run;
    logic [RW-1:0] need;

    assign g    = {gate_up, gate_mid, gate_dn};
    assign need = (dead_cycles == '0) ? RW'(1) : {1'b0, dead_cycles};

    function automatic logic lvl_match(input logic [1:0] c, input logic [2:0] v);
        return (v == 3'b100 && c == 2'b01) ||
               (v == 3'b010 && c == 2'b00) ||
               (v == 3'b001 && c == 2'b11);
    endfunction

    // Consecutive sampled cycles with every gate low
    always_ff @(posedge clk) begin
        if (rst) begin
            off_run <= '0;
        end else if (g != 3'b000) begin
            off_run <= '0;
        end else if (off_run != {RW{1'b1}}) begin
            off_run <= off_run + 1'b1;
        end
    end

    // R7
    onehot_gates_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g));

    // R6
    reset_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (g == 3'b000));

    // R3
    change_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((g != 3'b000) && !lvl_match(level_cmd, g)) |=> (g == 3'b000));

    // R8
    steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((g != 3'b000) && lvl_match(level_cmd, g)) |=> (g == $past(g)));

    // R1
    level_map_chk: assert property (@(posedge clk) disable iff (rst)
        (g != 3'b000) |-> lvl_match($past(level_cmd), g));

    // R2
    illegal_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(level_cmd) == 2'b10) |-> (g == 3'b000));

    // R4
    dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((g != 3'b000) && ($past(g) == 3'b000)) |-> (off_run >= need));

endmodule

bind tleg_gate_seq tleg_gate_seq_chk #(.DEAD_W(DEAD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .level_cmd   (level_cmd),
    .dead_cycles (dead_cycles),
    .gate_up     (gate_up),
    .gate_mid    (gate_mid),
    .gate_dn     (gate_dn)
);

// File: tb/sim_tleg_gate_seq.sv
`timescale 1ns/1ps
module sim_tleg_gate_seq;

    localparam int DEAD_W = 8;
    localparam int WATCHDOG_CYCLES = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        level_cmd = 2'b00;
    logic [DEAD_W-1:0] dead_cycles = '0;
    logic              gate_up, gate_mid, gate_dn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench reference state
    bit       held = 1'b1;
    bit       from_reset = 1'b0;
    bit       restarted = 1'b0;
    logic [1:0] cur = 2'b10;
    int       age = 0;

    always #10 clk = ~clk;   // 50 MHz

    tleg_gate_seq #(.DEAD_W(DEAD_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .level_cmd   (level_cmd),
        .dead_cycles (dead_cycles),
        .gate_up     (gate_up),
        .gate_mid    (gate_mid),
        .gate_dn     (gate_dn)
    );

    function automatic int eff_gap(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [2:0] lvl_to_gates(input logic [1:0] c);
        case (c)
            2'b01:   return 3'b100;
            2'b00:   return 3'b010;
            2'b11:   return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gates actual=%b expected=%b (cmd=%b dead=%0d age=%0d)",
                     tag, act, exp, cur, dead_cycles, age);
        end
    endtask

    // One clock: drive request, update reference at the edge, compare mid-cycle
    task automatic cyc(input logic [1:0] c);
        logic [2:0] exp_g;
        logic [2:0] act_g;
        string tag;
        int eff;
        level_cmd = c;
        @(posedge clk);
        eff = eff_gap(int'(dead_cycles));
        if (rst) begin
            held = 1'b1;
        end else if (held || c != cur) begin
            restarted  = !held && (age < eff);
            from_reset = held;
            held = 1'b0;
            cur  = c;
            age  = 0;
        end else begin
            age++;
        end
        @(negedge clk);
        exp_g = (held || age < eff) ? 3'b000 : lvl_to_gates(cur);
        act_g = {gate_up, gate_mid, gate_dn};
        if (held)                tag = "R6";
        else if (from_reset && age < eff) tag = "R6";
        else if (cur == 2'b10)   tag = "R2";
        else if (age == 0)       tag = "R3";
        else if (age < eff)      tag = restarted ? "R5" : "R4";
        else if (age == eff)     tag = "R1";
        else                     tag = "R8";
        check(tag, act_g, exp_g);
        // R7: one-hot or all low, whatever the stimulus
        n_checks++;
        if ($countones(act_g) > 1) begin
            n_fail++;
            $display("FAIL R7: gates actual=%b expected at most one high", act_g);
        end
    endtask

    task automatic do_reset(input int d, input int len, input logic [1:0] c);
        rst = 1'b1;
        dead_cycles = DEAD_W'(d);
        for (int i = 0; i < len; i++) cyc(c);
        rst = 1'b0;
    endtask

    task automatic hold(input logic [1:0] c, input int n);
        for (int i = 0; i < n; i++) cyc(c);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        int gaps [5] = '{0, 1, 2, 3, 6};
        @(negedge clk);
        // R6: reset state and release with a long reset held on a legal level
        do_reset(3, 6, 2'b11);
        hold(2'b11, 8);

        // R1 R2 R3 R4 R8: every ordered pair of codes over several gap lengths
        foreach (gaps[k]) begin
            int e = eff_gap(gaps[k]);
            do_reset(gaps[k], 2, 2'b00);
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    hold(2'(a), e + 2);
                    hold(2'(b), e + 2);
                end
            end
        end

        // R5: re-change at every point inside the gap, including its last cycle
        for (int d = 2; d <= 5; d++) begin
            do_reset(d, 2, 2'b01);
            hold(2'b01, d + 2);
            for (int h = 1; h <= d; h++) begin
                hold(2'b11, h);
                hold(2'b00, h);
                hold(2'b01, d + 2);
            end
            hold(2'b11, 1);
            hold(2'b10, 1);
            hold(2'b00, d + 3);
        end

        // R2: illegal code held for a long time after a driven level
        do_reset(2, 2, 2'b01);
        hold(2'b01, 5);
        hold(2'b10, 20);
        hold(2'b00, 6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule